// File: doc/BRIEF.md
# Prioritized Interrupt Controller with Single-Processor Interface

This block gathers up to 64 interrupt lines and drives one processor interrupt request. Software reaches it through a register bus split into two windows. The distributor window holds, for each source, an enable bit, a pending bit, an active bit and a 4-bit priority. It also holds a global forwarding switch and a read-only type word that gives the size of the block. The processor window holds a priority mask, an acknowledge register and an end-of-interrupt register.

Each source is either level-sensitive or pulse-sensitive, chosen per line by a parameter. A level source marks itself pending on every cycle its line is high. A pulse source marks itself pending only on a rising edge. Among enabled, pending and not yet active sources, the one with the lowest priority value wins, and a tie goes to the lower ID. The winner is forwarded only if three conditions hold: forwarding is on, its priority value is below the mask, and its priority value is below that of every interrupt already in service.

Reading the acknowledge register takes the winner into service. Writing its ID to the end-of-interrupt register ends service.

Top module: `irq_ctrl`

## Requirements
- R1: After reset all enables, pending bits, active bits and priorities read 0, the mask is 0, forwarding is off, `irq_out` is low and an acknowledge read returns 1023.
- R2: Writing 1 to bit n of set-enable word k (byte address 0x100+4k) sets the enable of interrupt 32k+n. Writing 1 to the same bit of clear-enable word k (0x180+4k) clears it. Bits written as 0 change nothing. Both words read back the current enables.
- R3: Set-pending words (0x200+4k) and clear-pending words (0x280+4k) act on pending bits with the same write-one rule, and both read back the pending bits. Active bits read at 0x300+4k.
- R4: Priority word w (0x400+4w) holds interrupt 4w+j in byte j. Only bits 7:4 of each byte are stored, and bits 3:0 read as 0. A lower value means a higher priority.
- R5: The mask register (0x1000) keeps bits 7:4. An interrupt is forwarded only if its priority is strictly below the mask.
- R6: An acknowledge read (0x1004) returns the ID in bits 9:0 with bits 31:10 zero. It returns 1023 when no interrupt is forwardable.
- R7: A successful acknowledge clears the pending bit of that interrupt and sets its active bit. `irq_out` then stays low unless a strictly higher-priority interrupt becomes pending.
- R8: Writing an ID to the end-of-interrupt register (0x1008) clears that active bit. An ID that is not active is ignored.
- R9: Control word bit 0 (0x000) enables forwarding. When it is 0, `irq_out` is low and an acknowledge returns 1023, and pending state is kept.
- R10: The type word (0x004) reads (NUM_IRQ/32)-1 in bits 4:0.
- R11: Among forwardable interrupts the lowest priority value wins. Equal priorities go to the lowest ID.
- R12: A level source is re-marked pending on each cycle its line is high. A pulse source is marked pending only on a rising edge of its line. In the default build, IDs 48 to 63 are pulse sources.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_IRQ | Interrupt source lines |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 13 | Byte address; bit 12 selects the processor window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| irq_out | output | 1 | Interrupt request to the processor |

## Verification
Register writes and source lines take effect at the clock edge that samples them, and `irq_out` follows from the stored state without a further register, so it is due just after that same edge. Read data is registered: it appears after the edge of the read strobe, and the side effects of an acknowledge take place at that same edge. The bench changes inputs on falling edges and samples every result on the next falling edge. Results that depend on one more edge are sampled one cycle later: a level source that pends again after an acknowledge, and a pulse source that is held high.

// File: rtl/irqc_pkg.sv
package irqc_pkg;

    localparam int PRIO_W = 4;
    localparam int ID_W   = 10;
    localparam int ADDR_W = 13;
    localparam logic [ID_W-1:0] NO_IRQ = 10'd1023;

    typedef enum logic [3:0] {
        RG_NONE, RG_CTRL, RG_TYPE, RG_SETEN, RG_CLREN, RG_SETPD,
        RG_CLRPD, RG_ACTV, RG_PRIO, RG_MASK, RG_ACK, RG_EOI
    } reg_e;

    typedef struct packed {
        logic              valid;
        logic [PRIO_W-1:0] prio;
        logic [ID_W-1:0]   id;
    } pick_t;

    function automatic reg_e decode_reg(input logic [ADDR_W-1:0] a);
        reg_e k;
        k = RG_NONE;
        if (a[1:0] == 2'b00) begin
            if (a[12]) begin
                case (a[11:0])
                    12'h000: k = RG_MASK;
                    12'h004: k = RG_ACK;
                    12'h008: k = RG_EOI;
                    default: k = RG_NONE;
                endcase
            end else if (a[11:0] == 12'h000) begin
                k = RG_CTRL;
            end else if (a[11:0] == 12'h004) begin
                k = RG_TYPE;
            end else if (a[11:10] == 2'b01) begin
                k = RG_PRIO;
            end else begin
                case (a[11:7])
                    5'b00010: k = RG_SETEN;
                    5'b00011: k = RG_CLREN;
                    5'b00100: k = RG_SETPD;
                    5'b00101: k = RG_CLRPD;
                    5'b00110: k = RG_ACTV;
                    default:  k = RG_NONE;
                endcase
            end
        end
        return k;
    endfunction

endpackage

// File: rtl/irqc_pick.sv
module irqc_pick
    import irqc_pkg::*;
#(
    parameter int NUM_IRQ = 64
) (
    input  logic [NUM_IRQ-1:0]        req,
    input  logic [NUM_IRQ*PRIO_W-1:0] prio,
    output pick_t                     best
);

    always_comb begin
        best       = '0;
        best.id    = NO_IRQ;
        for (int i = 0; i < NUM_IRQ; i++) begin
            // strict compare while scanning upward keeps the lowest ID on ties
            if (req[i] && (!best.valid || prio[i*PRIO_W +: PRIO_W] < best.prio)) begin
                best.valid = 1'b1;
                best.prio  = prio[i*PRIO_W +: PRIO_W];
                best.id    = ID_W'(i);
            end
        end
    end

endmodule

// File: rtl/irqc_state.sv
module irqc_state
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter logic [63:0] PULSE_SRC = 64'hFFFF_0000_0000_0000
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_IRQ-1:0]        irq_in,
    input  logic                      wr_en,
    input  reg_e                      wr_kind,
    input  logic [4:0]                wr_word,
    input  logic [7:0]                wr_pword,
    input  logic [31:0]               wr_data,
    input  logic                      take_en,
    input  logic [ID_W-1:0]           take_id,
    input  logic                      eoi_en,
    input  logic [ID_W-1:0]           eoi_id,
    output logic [NUM_IRQ-1:0]        enable,
    output logic [NUM_IRQ-1:0]        pending,
    output logic [NUM_IRQ-1:0]        active,
    output logic [NUM_IRQ*PRIO_W-1:0] prio
);

    localparam logic [NUM_IRQ-1:0] ONE = NUM_IRQ'(1);

    for (genvar i = 0; i < NUM_IRQ; i++) begin : g_src
        localparam logic [4:0]      W  = 5'(i / 32);
        localparam int              B  = i % 32;
        localparam logic [7:0]      PW = 8'(i / 4);
        localparam int              PB = (i % 4) * 8 + 4;
        localparam logic [ID_W-1:0] ID = ID_W'(i);

        logic              line_hit;
        logic              bit_hit;
        logic              en_q;
        logic              pd_q;
        logic              ac_q;
        logic [PRIO_W-1:0] pr_q;

        if (PULSE_SRC[i]) begin : g_pulse
            logic prev_q;
            always_ff @(posedge clk) begin
                if (rst) prev_q <= 1'b0;
                else     prev_q <= irq_in[i];
            end
            assign line_hit = irq_in[i] & ~prev_q;
        end else begin : g_level
            assign line_hit = irq_in[i];
        end

        assign bit_hit = wr_en && (wr_word == W) && wr_data[B];

        always_ff @(posedge clk) begin
            if (rst) begin
                en_q <= 1'b0;
                pd_q <= 1'b0;
                ac_q <= 1'b0;
                pr_q <= '0;
            end else begin
                if (bit_hit && wr_kind == RG_SETEN) en_q <= 1'b1;
                if (bit_hit && wr_kind == RG_CLREN) en_q <= 1'b0;
                if (line_hit)                       pd_q <= 1'b1;
                if (bit_hit && wr_kind == RG_SETPD) pd_q <= 1'b1;
                if (bit_hit && wr_kind == RG_CLRPD) pd_q <= 1'b0;
                if (take_en && take_id == ID) begin
                    pd_q <= 1'b0;
                    ac_q <= 1'b1;
                end else if (eoi_en && eoi_id == ID) begin
                    ac_q <= 1'b0;
                end
                if (wr_en && wr_kind == RG_PRIO && wr_pword == PW)
                    pr_q <= wr_data[PB +: PRIO_W];
            end
        end

        assign enable[i]                 = en_q;
        assign pending[i]                = pd_q;
        assign active[i]                 = ac_q;
        assign prio[i*PRIO_W +: PRIO_W]  = pr_q;
    end

    AST_TAKE_MARKS: assert property (@(posedge clk) disable iff (rst)
        take_en |=> |(active & (ONE << $past(take_id)))); // R7

    AST_TAKE_UNPENDS: assert property (@(posedge clk) disable iff (rst)
        (take_en && !wr_en) |=> ($countones(active) == $past($countones(active)) + 1)); // R7

    AST_EOI_STRAY: assert property (@(posedge clk) disable iff (rst)
        (eoi_en && !take_en && !(|(active & (ONE << eoi_id)))) |=> $stable(active)); // R8

    AST_EN_STABLE: assert property (@(posedge clk) disable iff (rst)
        !(wr_en && (wr_kind == RG_SETEN || wr_kind == RG_CLREN)) |=> $stable(enable)); // R2

    AST_ACT_GROW: assert property (@(posedge clk) disable iff (rst)
        !take_en |=> ($countones(active) <= $past($countones(active)))); // R7

endmodule

// File: rtl/irqc_cpu_if.sv
module irqc_cpu_if
    import irqc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              mask_we,
    input  logic [PRIO_W-1:0] mask_wdata,
    input  logic              dist_en,
    input  pick_t             cand,
    input  logic              run_valid,
    input  logic [PRIO_W-1:0] run_prio,
    output logic [PRIO_W-1:0] mask_q,
    output logic              signal_ok,
    output logic              irq_out
);

    logic [PRIO_W:0] run_level;

    always_ff @(posedge clk) begin
        if (rst)          mask_q <= '0;
        else if (mask_we) mask_q <= mask_wdata;
    end

    // idle level sits one above the lowest priority so any priority beats it
    assign run_level = run_valid ? {1'b0, run_prio} : (PRIO_W+1)'(1 << PRIO_W);

    assign signal_ok = dist_en && cand.valid
                    && (cand.prio < mask_q)
                    && ({1'b0, cand.prio} < run_level);
    assign irq_out   = signal_ok;

    AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
        !mask_we |=> $stable(mask_q)); // R5

    AST_MASK_ZERO: assert property (@(posedge clk) disable iff (rst)
        (mask_q == '0) |-> !irq_out); // R5

endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irqc_pkg::*;
#(
    parameter int          NUM_IRQ   = 64,
    parameter logic [63:0] PULSE_SRC = 64'hFFFF_0000_0000_0000
) (
    input  logic               clk,
    input  logic               rst,
    input  logic [NUM_IRQ-1:0] irq_in,
    input  logic               bus_wr,
    input  logic               bus_rd,
    input  logic [12:0]        bus_addr,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_out
);

    localparam int                 WORDS    = NUM_IRQ / 32;
    localparam logic [4:0]         TYPE_VAL = 5'(WORDS - 1);
    localparam logic [NUM_IRQ-1:0] ONE      = NUM_IRQ'(1);

    reg_e                      kind;
    logic [4:0]                word;
    logic [7:0]                pword;
    logic                      dist_en_q;
    logic [NUM_IRQ-1:0]        enable;
    logic [NUM_IRQ-1:0]        pending;
    logic [NUM_IRQ-1:0]        active;
    logic [NUM_IRQ*PRIO_W-1:0] prio;
    pick_t                     cand;
    pick_t                     run;
    logic [PRIO_W-1:0]         mask_q;
    logic                      signal_ok;
    logic                      take_en;
    logic                      eoi_en;
    logic [31:0]               rd_mux;

    assign kind    = decode_reg(bus_addr);
    assign word    = bus_addr[6:2];
    assign pword   = bus_addr[9:2];
    assign take_en = bus_rd && (kind == RG_ACK) && signal_ok;
    assign eoi_en  = bus_wr && (kind == RG_EOI);

    always_ff @(posedge clk) begin
        if (rst)                          dist_en_q <= 1'b0;
        else if (bus_wr && kind == RG_CTRL) dist_en_q <= bus_wdata[0];
    end

    irqc_state #(.NUM_IRQ(NUM_IRQ), .PULSE_SRC(PULSE_SRC)) u_state (
        .clk      (clk),
        .rst      (rst),
        .irq_in   (irq_in),
        .wr_en    (bus_wr),
        .wr_kind  (kind),
        .wr_word  (word),
        .wr_pword (pword),
        .wr_data  (bus_wdata),
        .take_en  (take_en),
        .take_id  (cand.id),
        .eoi_en   (eoi_en),
        .eoi_id   (bus_wdata[ID_W-1:0]),
        .enable   (enable),
        .pending  (pending),
        .active   (active),
        .prio     (prio)
    );

    irqc_pick #(.NUM_IRQ(NUM_IRQ)) u_pick_cand (
        .req  (pending & enable & ~active),
        .prio (prio),
        .best (cand)
    );

    irqc_pick #(.NUM_IRQ(NUM_IRQ)) u_pick_run (
        .req  (active),
        .prio (prio),
        .best (run)
    );

    irqc_cpu_if u_cpu (
        .clk        (clk),
        .rst        (rst),
        .mask_we    (bus_wr && kind == RG_MASK),
        .mask_wdata (bus_wdata[7:4]),
        .dist_en    (dist_en_q),
        .cand       (cand),
        .run_valid  (run.valid),
        .run_prio   (run.prio),
        .mask_q     (mask_q),
        .signal_ok  (signal_ok),
        .irq_out    (irq_out)
    );

    always_comb begin
        rd_mux = '0;
        case (kind)
            RG_CTRL: rd_mux[0]   = dist_en_q;
            RG_TYPE: rd_mux[4:0] = TYPE_VAL;
            RG_SETEN, RG_CLREN: begin
                for (int k = 0; k < WORDS; k++)
                    if (word == 5'(k)) rd_mux = enable[k*32 +: 32];
            end
            RG_SETPD, RG_CLRPD: begin
                for (int k = 0; k < WORDS; k++)
                    if (word == 5'(k)) rd_mux = pending[k*32 +: 32];
            end
            RG_ACTV: begin
                for (int k = 0; k < WORDS; k++)
                    if (word == 5'(k)) rd_mux = active[k*32 +: 32];
            end
            RG_PRIO: begin
                for (int j = 0; j < NUM_IRQ; j++)
                    if (pword == 8'(j / 4))
                        rd_mux[(j % 4) * 8 + 4 +: PRIO_W] = prio[j*PRIO_W +: PRIO_W];
            end
            RG_MASK: rd_mux[7:4] = mask_q;
            RG_ACK:  rd_mux[ID_W-1:0] = signal_ok ? cand.id : NO_IRQ;
            default: rd_mux = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst)         bus_rdata <= '0;
        else if (bus_rd) bus_rdata <= rd_mux;
    end

    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (bus_rd && kind == RG_ACK && !irq_out) |=> (bus_rdata == 32'd1023)); // R6

    AST_RUN_IS_ACTIVE: assert property (@(posedge clk) disable iff (rst)
        run.valid |-> |(active & (ONE << run.id))); // R7

    AST_OFF_QUIET: assert property (@(posedge clk) disable iff (rst)
        !dist_en_q |-> !irq_out); // R9

endmodule

// File: tb/test_irq_ctrl.sv
module test_irq_ctrl;

    localparam int NUM_IRQ = 64;

    logic               clk = 1'b0;
    logic               rst;
    logic [NUM_IRQ-1:0] irq_in;
    logic               bus_wr;
    logic               bus_rd;
    logic [12:0]        bus_addr;
    logic [31:0]        bus_wdata;
    logic [31:0]        bus_rdata;
    logic               irq_out;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    localparam logic [12:0] A_CTRL = 13'h000;
    localparam logic [12:0] A_TYPE = 13'h004;
    localparam logic [12:0] A_SEN  = 13'h100;
    localparam logic [12:0] A_CEN  = 13'h180;
    localparam logic [12:0] A_SPD  = 13'h200;
    localparam logic [12:0] A_CPD  = 13'h280;
    localparam logic [12:0] A_ACT  = 13'h300;
    localparam logic [12:0] A_PRI  = 13'h400;
    localparam logic [12:0] A_MASK = 13'h1000;
    localparam logic [12:0] A_ACK  = 13'h1004;
    localparam logic [12:0] A_EOI  = 13'h1008;

    always #5 clk = ~clk;

    irq_ctrl #(.NUM_IRQ(NUM_IRQ)) i_irq_ctrl (
        .clk       (clk),
        .rst       (rst),
        .irq_in    (irq_in),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_out   (irq_out)
    );

    task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    task automatic wr(input logic [12:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [12:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        @(negedge clk);
        bus_rd = 1'b0;
        d = bus_rdata;
    endtask

    task automatic cleanup();
        irq_in = '0;
        for (int k = 0; k < 2; k++) begin
            wr(A_CEN + 13'(4*k), 32'hFFFF_FFFF);
            wr(A_CPD + 13'(4*k), 32'hFFFF_FFFF);
        end
        for (int id = 0; id < NUM_IRQ; id++) wr(A_EOI, 32'(id));
        for (int w = 0; w < NUM_IRQ/4; w++) wr(A_PRI + 13'(4*w), 32'h0);
    endtask

    task automatic t_reset();
        logic [31:0] d;
        chk("R1 irq_out low", 32'(irq_out), 32'd0);
        rd(A_CTRL, d);        chk("R1 ctrl", d, 32'd0);
        rd(A_TYPE, d);        chk("R10 type", d, 32'd1);
        rd(A_SEN, d);         chk("R1 enable w0", d, 32'd0);
        rd(A_SEN + 13'd4, d); chk("R1 enable w1", d, 32'd0);
        rd(A_SPD + 13'd4, d); chk("R1 pending w1", d, 32'd0);
        rd(A_ACT, d);         chk("R1 active w0", d, 32'd0);
        rd(A_PRI + 13'd8, d); chk("R1 prio w2", d, 32'd0);
        rd(A_MASK, d);        chk("R1 mask", d, 32'd0);
        rd(A_ACK, d);         chk("R1 ack idle", d, 32'd1023);
    endtask

    task automatic t_enable();
        logic [31:0] d;
        wr(A_SEN + 13'd4, 32'h0000_0005);
        rd(A_CEN + 13'd4, d); chk("R2 set-enable ids 32,34", d, 32'h5);
        wr(A_SEN + 13'd4, 32'h0);
        rd(A_SEN + 13'd4, d); chk("R2 zero write no effect", d, 32'h5);
        wr(A_CEN + 13'd4, 32'h1);
        rd(A_SEN + 13'd4, d); chk("R2 clear-enable id 32", d, 32'h4);
        rd(A_SEN, d);         chk("R2 word0 untouched", d, 32'h0);
        cleanup();
    endtask

    task automatic t_pending();
        logic [31:0] d;
        wr(A_SPD, 32'h8000_0001);
        rd(A_CPD, d); chk("R3 set-pending", d, 32'h8000_0001);
        wr(A_CPD, 32'h0);
        rd(A_SPD, d); chk("R3 zero write no effect", d, 32'h8000_0001);
        wr(A_CPD, 32'h1);
        rd(A_SPD, d); chk("R3 clear-pending", d, 32'h8000_0000);
        cleanup();
    endtask

    task automatic t_prio();
        logic [31:0] d;
        wr(A_PRI + 13'd36, 32'h1234_5678);
        rd(A_PRI + 13'd36, d); chk("R4 upper nibbles kept", d, 32'h1030_5070);
        rd(A_PRI + 13'd32, d); chk("R4 neighbour word", d, 32'h0);
        cleanup();
    endtask

    task automatic t_flow();
        logic [31:0] d;
        wr(A_CTRL, 32'h1);
        wr(A_MASK, 32'hF0);
        wr(A_PRI + 13'd40, 32'h0000_0080);   // id 40 priority 0x80
        wr(A_SEN + 13'd4, 32'h0000_0100);    // enable id 40
        @(negedge clk); irq_in[40] = 1'b1;
        @(negedge clk); chk("R12 level line raises irq", 32'(irq_out), 32'd1);
        rd(A_ACK, d);   chk("R6 ack id 40", d, 32'd40);
        chk("R7 irq low after ack", 32'(irq_out), 32'd0);
        rd(A_SPD + 13'd4, d); chk("R12 level re-pends", d, 32'h100);
        rd(A_ACT + 13'd4, d); chk("R7 active set", d, 32'h100);
        wr(A_EOI, 32'd41);
        rd(A_ACT + 13'd4, d); chk("R8 stray EOI ignored", d, 32'h100);
        chk("R8 irq still low", 32'(irq_out), 32'd0);
        wr(A_EOI, 32'd40);
        rd(A_ACT + 13'd4, d); chk("R8 EOI clears active", d, 32'h0);
        chk("R8 irq returns after EOI", 32'(irq_out), 32'd1);
        wr(A_MASK, 32'h80);
        chk("R5 equal to mask blocked", 32'(irq_out), 32'd0);
        wr(A_MASK, 32'h90);
        chk("R5 below mask passes", 32'(irq_out), 32'd1);
        wr(A_CTRL, 32'h0);
        chk("R9 forwarding off", 32'(irq_out), 32'd0);
        rd(A_ACK, d); chk("R9 ack idle when off", d, 32'd1023);
        rd(A_SPD + 13'd4, d); chk("R9 pending kept", d, 32'h100);
        cleanup();
    endtask

    task automatic t_arb();
        logic [31:0] d;
        wr(A_CTRL, 32'h1);
        wr(A_MASK, 32'hF0);
        wr(A_PRI,         32'h4000_0000);    // id 3 -> 0x40
        wr(A_PRI + 13'd4, 32'h0000_4000);    // id 5 -> 0x40
        wr(A_PRI + 13'd8, 32'h0000_2000);    // id 9 -> 0x20
        wr(A_SEN, 32'h0000_0228);
        wr(A_SPD, 32'h0000_0228);
        rd(A_ACK, d); chk("R11 lowest value wins", d, 32'd9);
        chk("R7 lower priority held off", 32'(irq_out), 32'd0);
        rd(A_ACK, d); chk("R6 ack none while running", d, 32'd1023);
        wr(A_EOI, 32'd9);
        rd(A_ACK, d); chk("R11 tie goes to lower id", d, 32'd3);
        wr(A_EOI, 32'd3);
        rd(A_ACK, d); chk("R11 remaining id", d, 32'd5);
        wr(A_SPD, 32'h0000_0200);
        chk("R7 higher priority breaks through", 32'(irq_out), 32'd1);
        rd(A_ACK, d); chk("R7 nested ack", d, 32'd9);
        rd(A_ACT, d); chk("R7 both active", d, 32'h220);
        cleanup();
    endtask

    task automatic t_pulse();
        logic [31:0] d;
        wr(A_CTRL, 32'h1);
        wr(A_MASK, 32'hF0);
        wr(A_SEN + 13'd4, 32'h0004_0000);    // enable id 50
        @(negedge clk); irq_in[50] = 1'b1;
        @(negedge clk); chk("R12 pulse edge raises irq", 32'(irq_out), 32'd1);
        rd(A_ACK, d);   chk("R12 ack id 50", d, 32'd50);
        repeat (3) @(negedge clk);
        rd(A_SPD + 13'd4, d); chk("R12 held pulse no re-pend", d, 32'h0);
        wr(A_EOI, 32'd50);
        chk("R12 irq low with line held", 32'(irq_out), 32'd0);
        @(negedge clk); irq_in[50] = 1'b0;
        @(negedge clk); irq_in[50] = 1'b1;
        @(negedge clk);
        rd(A_SPD + 13'd4, d); chk("R12 new edge pends", d, 32'h0004_0000);
        cleanup();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            bad++;
            total++;
            $display("FAIL watchdog expired got=running exp=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; irq_in = '0; bus_wr = 1'b0; bus_rd = 1'b0;
        bus_addr = '0; bus_wdata = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_enable();
        t_pending();
        t_prio();
        t_flow();
        t_arb();
        t_pulse();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule